// File: doc/BRIEF.md
# TDM Slave Serial Audio Port

This block is the serial edge of an audio path that runs as a timing slave. An external device supplies the bit clock and a frame sync. The port counts bit positions within a frame that holds a fixed number of slots. In the slots that are enabled, it shifts 16-bit words out of a transmit FIFO and into a receive FIFO. Transmit and receive share the one bit clock and the one frame sync. The port keeps no second clock pair for receive.

The serial inputs are oversampled in the system clock domain through a short synchronizer chain, and the bit-clock edges are found there. A frame sync is a single bit-clock-wide pulse. The port samples it on a falling edge, and the next bit period is the most significant bit of slot 0. Every frame sync restarts the count, so a pulse in an unexpected place realigns the port at once. Two request lines report when the receive FIFO has filled to its mark and when the transmit FIFO has room for a burst. A DMA engine or a processor can drain and refill the FIFOs in bursts from these lines. Two sticky flags record transmit underrun and receive overrun.

Top module: `tdm_slave_port`

## Requirements
- R1: After reset, sd_oe and sd_o are low, rx_valid and rx_req are low, tx_req is high, and both sticky flags are clear.
- R2: Until the first frame sync has been sampled, no slot is active: sd_oe stays low and no word enters the receive FIFO.
- R3: A frame sync sampled high on a bit-clock falling edge makes the next bit period bit 15 of slot 0. A frame has 16 slots of 16 bits each, so a frame is 256 bit periods.
- R4: Only slots whose bit is set in SLOT_EN move data. The default is 16'h0318, which enables slots 3, 4, 8 and 9. In every other slot sd_o and sd_oe are low and no FIFO word is read or written.
- R5: In an active slot the transmit word is taken from the transmit FIFO at the rising edge that starts the slot. It is driven MSB first, and sd_o changes after each rising edge.
- R6: In an active slot sd_i is sampled on falling edges, MSB first. After the 16th bit the word is written to the receive FIFO.
- R7: rx_req is high exactly while the receive FIFO holds at least RX_MARK (4) words.
- R8: tx_req is high exactly while the transmit FIFO has at least TX_MARK (4) free entries, out of a depth of 8.
- R9: If the transmit FIFO is empty when an active slot starts, zeros are sent for that slot and tx_underrun sets and stays set until reset.
- R10: If the receive FIFO is full when a word completes, that word is dropped, the stored words are kept, and rx_overrun sets and stays set until reset.
- R11: A frame sync that arrives at any bit position restarts slot counting from slot 0.
- R12: Both FIFOs keep first-in first-out order. rx_data shows the oldest word while rx_valid is high, and rx_pop removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | External bit clock |
| fs_i | input | 1 | External frame sync pulse |
| sd_i | input | 1 | Serial receive data |
| sd_o | output | 1 | Serial transmit data |
| sd_oe | output | 1 | Transmit output enable, high only in active slots |
| tx_push | input | 1 | Write tx_data into the transmit FIFO |
| tx_data | input | 16 | Transmit word |
| tx_req | output | 1 | Transmit FIFO has room for a burst |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_data | output | 16 | Head of the receive FIFO |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_req | output | 1 | Receive FIFO reached its mark |
| tx_underrun | output | 1 | Sticky transmit underrun flag |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The assertions take for granted that the bit clock is slow against the system clock. Each bit-clock phase must last several system cycles, so that every synchronized edge is seen once. They also assume that frame sync and serial data change only with the rising bit-clock edge. The stimulus holds each phase for six system cycles and drives the frame sync and receive data together with the rising edge. FIFO pushes and pops happen only while the bit clock is idle and low. The bench never pushes into a full transmit FIFO.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tdm_sync.sv
module tdm_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= '0;
            else        q <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= '0;
            else        q <= g_stage[s-1].q;
      end
   end

   assign dout = g_stage[STAGES-1].q;
endmodule

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
   parameter int POS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sck_s,
   input  logic             fs_s,
   output logic             sck_rise,
   output logic             sck_fall,
   output logic [POS_W-1:0] pos,
   output logic             synced
);
   logic sck_prev;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_s;

   assign sck_rise = sck_s & ~sck_prev;
   assign sck_fall = ~sck_s & sck_prev;

   // pos names the bit to be driven at the next rise and sampled at the next fall
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         pos    <= '0;
         synced <= 1'b0;
      end else if (sck_fall) begin
         if (fs_s) begin
            pos    <= '0;
            synced <= 1'b1;
         end else begin
            pos    <= pos + 1'b1;
         end
      end
endmodule

// File: rtl/tdm_fifo.sv
module tdm_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic [CW-1:0]    count
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic             do_wr, do_rd;

   assign do_wr   = wr_en && (count != CW'(DEPTH));
   assign do_rd   = rd_en && (count != '0);
   assign rd_data = mem[rp];

   always_ff @(posedge clk)
      if (do_wr) mem[wp] <= wr_data;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_wr) wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
         count <= count + CW'(do_wr) - CW'(do_rd);
      end
endmodule

// File: rtl/tdm_slave_port.sv
module tdm_slave_port #(
   parameter int          WORD_W      = 16,
   parameter int          SLOTS       = 16,
   parameter logic [15:0] SLOT_EN     = 16'h0318,
   parameter int          FIFO_DEPTH  = 8,
   parameter int          RX_MARK     = 4,
   parameter int          TX_MARK     = 4,
   parameter int          SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_i,
   input  logic              fs_i,
   input  logic              sd_i,
   output logic              sd_o,
   output logic              sd_oe,
   input  logic              tx_push,
   input  logic [WORD_W-1:0] tx_data,
   output logic              tx_req,
   input  logic              rx_pop,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_req,
   output logic              tx_underrun,
   output logic              rx_overrun
);
   localparam int BIT_W  = $clog2(WORD_W);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam int POS_W  = BIT_W + SLOT_W;
   localparam int CW     = $clog2(FIFO_DEPTH + 1);

   if (!tdm_pkg::is_pow2(WORD_W) || !tdm_pkg::is_pow2(SLOTS) || SLOTS > 16)
      begin : g_bad_frame
         $error("WORD_W and SLOTS must be powers of two, SLOTS at most 16");
      end
   if (!tdm_pkg::is_pow2(FIFO_DEPTH) || RX_MARK > FIFO_DEPTH || TX_MARK > FIFO_DEPTH)
      begin : g_bad_fifo
         $error("FIFO_DEPTH must be a power of two not below either mark");
      end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // synchronized serial inputs, all through the same chain
   logic sck_s, fs_s, sd_s;
   tdm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .din({sck_i, fs_i, sd_i}), .dout({sck_s, fs_s, sd_s})
   );

   logic             sck_rise, sck_fall, frame_synced;
   logic [POS_W-1:0] pos;
   tdm_slot_timer #(.POS_W(POS_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .fs_s(fs_s),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .pos(pos), .synced(frame_synced)
   );

   logic [SLOT_W-1:0] slot;
   logic [BIT_W-1:0]  bidx;
   logic              slot_on;
   assign slot    = pos[POS_W-1:BIT_W];
   assign bidx    = pos[BIT_W-1:0];
   assign slot_on = frame_synced && SLOT_EN[slot];

   // transmit side
   logic [WORD_W-1:0] tx_head, tx_sh, tx_word;
   logic [CW-1:0]     tx_cnt;
   logic              tx_empty, tx_rd, slot_start;
   assign tx_empty   = (tx_cnt == '0);
   assign slot_start = sck_rise && slot_on && (bidx == '0);
   assign tx_rd      = slot_start && !tx_empty;
   assign tx_word    = tx_empty ? '0 : tx_head;
   assign tx_req     = (CW'(FIFO_DEPTH) - tx_cnt) >= CW'(TX_MARK);

   tdm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .wr_en(tx_push), .wr_data(tx_data),
      .rd_en(tx_rd), .rd_data(tx_head), .count(tx_cnt)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         tx_sh       <= '0;
         sd_o        <= 1'b0;
         sd_oe       <= 1'b0;
         tx_underrun <= 1'b0;
      end else if (sck_rise) begin
         if (!slot_on) begin
            sd_o  <= 1'b0;
            sd_oe <= 1'b0;
         end else if (bidx == '0) begin
            tx_sh <= tx_word;
            sd_o  <= tx_word[WORD_W-1];
            sd_oe <= 1'b1;
            if (tx_empty) tx_underrun <= 1'b1;
         end else begin
            sd_o  <= tx_sh[~bidx];
            sd_oe <= 1'b1;
         end
      end

   // receive side
   logic [WORD_W-1:0] rx_sh, rx_word;
   logic [CW-1:0]     rx_cnt;
   logic              rx_wr, rx_full;
   assign rx_word  = {rx_sh[WORD_W-2:0], sd_s};
   assign rx_wr    = sck_fall && slot_on && (bidx == BIT_W'(WORD_W - 1));
   assign rx_full  = (rx_cnt == CW'(FIFO_DEPTH));
   assign rx_valid = (rx_cnt != '0);
   assign rx_req   = rx_cnt >= CW'(RX_MARK);

   tdm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .wr_en(rx_wr), .wr_data(rx_word),
      .rd_en(rx_pop), .rd_data(rx_data), .count(rx_cnt)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         rx_sh      <= '0;
         rx_overrun <= 1'b0;
      end else if (sck_fall && slot_on) begin
         rx_sh <= rx_word;
         if (rx_wr && rx_full) rx_overrun <= 1'b1;
      end
endmodule

// File: rtl/tdm_slave_port_chk.sv
module tdm_slave_port_chk (
   input logic clk,
   input logic rst_n,
   input logic sd_o,
   input logic sd_oe,
   input logic tx_req,
   input logic tx_push,
   input logic rx_req,
   input logic rx_wr,
   input logic frame_synced,
   input logic tx_underrun,
   input logic rx_overrun
);
   assert_no_rx_unsynced_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_synced |-> !rx_wr);

   assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_oe |-> !sd_o);

   assert_oe_needs_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sd_oe |-> frame_synced);

   assert_rx_req_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_req) |-> $past(rx_wr));

   assert_tx_req_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_req) |-> $past(tx_push));

   assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun |=> tx_underrun);

   assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |=> rx_overrun);
endmodule

bind tdm_slave_port tdm_slave_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sd_o(sd_o), .sd_oe(sd_oe),
   .tx_req(tx_req), .tx_push(tx_push), .rx_req(rx_req), .rx_wr(rx_wr),
   .frame_synced(frame_synced), .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
);

// File: tb/tdm_slave_port_tb.sv
module tdm_slave_port_tb;
   localparam int          W     = 16;
   localparam logic [15:0] MASK  = 16'h0318;
   localparam int          DEPTH = 8;
   localparam int          HALF  = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, fs = 1'b0, sd = 1'b0;
   logic tx_push = 1'b0, rx_pop = 1'b0;
   logic [W-1:0] tx_data = '0;
   logic sd_o, sd_oe, tx_req, rx_valid, rx_req, tx_underrun, rx_overrun;
   logic [W-1:0] rx_data;

   always #5 clk = ~clk;

   tdm_slave_port u_dut (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .fs_i(fs), .sd_i(sd),
      .sd_o(sd_o), .sd_oe(sd_oe), .tx_push(tx_push), .tx_data(tx_data),
      .tx_req(tx_req), .rx_pop(rx_pop), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_req(rx_req), .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
   );

   int n_checks = 0, n_err = 0;
   bit finished = 0;

   // behavioural reference
   int           m_pos = 0;
   bit           m_sync = 0, m_under = 0, m_over = 0, exp_o = 0, exp_oe = 0;
   logic [W-1:0] m_txw = '0, m_rxsh = '0;
   logic [W-1:0] txq[$], rxq[$];

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit active();
      return m_sync && MASK[m_pos / W];
   endfunction

   task automatic model_rise();
      int b = m_pos % W;
      if (active()) begin
         if (b == 0) begin
            if (txq.size() > 0) m_txw = txq.pop_front();
            else begin m_txw = '0; m_under = 1; end
         end
         exp_o  = m_txw[W-1-b];
         exp_oe = 1;
      end else begin
         exp_o  = 0;
         exp_oe = 0;
      end
   endtask

   task automatic model_fall(input bit fsv, input bit sdv);
      if (active()) begin
         m_rxsh = {m_rxsh[W-2:0], sdv};
         if (m_pos % W == W - 1) begin
            if (rxq.size() < DEPTH) rxq.push_back(m_rxsh);
            else m_over = 1;
         end
      end
      if (fsv) begin m_pos = 0; m_sync = 1; end
      else m_pos = (m_pos + 1) % (16 * W);
   endtask

   task automatic bit_period(input bit fsv, input bit sdv);
      model_rise();
      @(negedge clk); sck = 1; fs = fsv; sd = sdv;
      repeat (HALF - 1) @(negedge clk);
      check(m_sync ? "R4 oe" : "R2 oe", W'(sd_oe), W'(exp_oe));
      check("R5 sd_o", W'(sd_o), W'(exp_o));
      check("R7 rx_req", W'(rx_req), W'(rxq.size() >= 4));
      check("R8 tx_req", W'(tx_req), W'((DEPTH - txq.size()) >= 4));
      check("R9 underrun", W'(tx_underrun), W'(m_under));
      check("R10 overrun", W'(rx_overrun), W'(m_over));
      @(negedge clk); sck = 0;
      model_fall(fsv, sdv);
      repeat (HALF - 1) @(negedge clk);
   endtask

   task automatic run_bits(input int n, input bit fs_first);
      for (int i = 0; i < n; i++) bit_period(fs_first && i == 0, 1'($urandom));
   endtask

   task automatic push_tx(input int n);
      for (int i = 0; i < n; i++) begin
         logic [W-1:0] v = W'($urandom);
         @(negedge clk); tx_push = 1; tx_data = v;
         txq.push_back(v);
         @(negedge clk); tx_push = 0;
      end
   endtask

   task automatic drain(input string req);
      int n = rxq.size();
      for (int i = 0; i < n; i++) begin
         logic [W-1:0] e = rxq.pop_front();
         @(negedge clk);
         check(req, W'(rx_valid), W'(1));
         check(req, rx_data, e);
         rx_pop = 1;
         @(negedge clk); rx_pop = 0;
      end
      @(negedge clk);
      check(req, W'(rx_valid), W'(0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      // R1 reset state
      check("R1 sd_oe", W'(sd_oe), W'(0));
      check("R1 sd_o", W'(sd_o), W'(0));
      check("R1 rx_valid", W'(rx_valid), W'(0));
      check("R1 rx_req", W'(rx_req), W'(0));
      check("R1 tx_req", W'(tx_req), W'(1));
      check("R1 flags", W'({tx_underrun, rx_overrun}), W'(0));

      run_bits(70, 0);             // R2: no frame sync yet
      check("R2 rx_valid", W'(rx_valid), W'(0));

      push_tx(4);
      run_bits(256, 1);            // R3 first aligned frame
      drain("R3");
      push_tx(5);                  // R8 drops below the mark
      run_bits(256, 1);
      drain("R6");
      run_bits(256, 1);            // R9: one word then underrun
      drain("R9");
      run_bits(256, 1);            // R10: fill then overflow
      run_bits(256, 1);
      run_bits(256, 1);
      drain("R10");
      push_tx(4);
      run_bits(50, 1);             // R11: sync arrives mid slot 3
      push_tx(4);
      run_bits(256, 1);
      drain("R11");
      push_tx(4);
      run_bits(256, 1);
      run_bits(20, 1);
      drain("R12");

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end
endmodule